// File: doc/BRIEF.md
# I2C Identification ROM Target

This block is an I2C target that answers one fixed 7-bit address and returns a constant ASCII identification string. A host reads the string to learn what kind of connector or adapter sits at the far end of the bus. The target samples the open-drain SCL and SDA lines with a fast system clock. It detects START, repeated START and STOP on the bus. It accepts a one-byte write that positions an internal read pointer. On a read it streams bytes from a 17-entry ROM, and every master ACK moves the pointer forward.

The pointer clamps at the final ROM location, which always reads 0xFF. Any STOP or reset returns the pointer to location zero, so a host can skip the pointer write and read the string straight from the start. A pointer write takes effect for a read that follows it through a repeated START. The enable input gates the whole target. While enable is low, the target never pulls SDA low.

The target only ever pulls SDA low, through an output-enable signal. It never stretches the clock. It works at the standard 100 kbit/s rate and at any slower or somewhat faster SCL, provided each SCL phase lasts well over ten system clocks.

Top module: `id_rom_i2c_target`

## Requirements
- R1: The target ACKs an address byte whose upper seven bits are 7'b1000000, which is 0x80 for a write and 0x81 for a read. It NACKs any other address and ignores the bus until the next START.
- R2: In a write, the first byte after the address loads the read pointer and is ACKed. Any further write bytes are NACKed.
- R3: On a read, the target sends the byte at the pointer, MSB first, with each bit valid while SCL is high. A master ACK (SDA low on the ninth clock) advances the pointer and starts the next byte.
- R4: The ROM holds the ASCII codes of "DP-HDMI ADAPTOR" at locations 0x00 to 0x0E, 0x04 at 0x0F and 0xFF at 0x10.
- R5: The pointer saturates at 0x10. Repeated ACKs at 0x10 resend 0xFF, and a written pointer above 0x10 is clamped to 0x10.
- R6: After a master NACK (SDA high on the ninth clock), the target releases SDA and drives nothing until the next START or STOP.
- R7: A STOP resets the pointer to 0x00, so a read with no pointer write returns the string from location 0x00.
- R8: While enable is low, SDA is never pulled low and no address is ACKed.
- R9: The target asserts its SDA pull-down only in the cycle after SCL has been seen low.
- R10: After reset, SDA is released and the pointer is 0x00.
- R11: A pulse on SCL or SDA lasting one system clock is filtered out and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High lets the target respond. Low keeps SDA released. |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain output enable) |

## Verification
Each line passes through two synchronizer flops, a three-tap majority filter and an edge register. Because of this, a change on the bus appears on sda_oe_o about six to seven system clocks after the SCL edge that caused it. The bench drives SCL with a quarter-bit period of 16 clocks. It changes SDA only a full quarter after SCL falls and samples SDA a full quarter after SCL rises. Every ACK bit and data bit is therefore read long after the target's response has settled, and never near a transition. The checks that prove something is ignored watch sda_oe_o for the whole window of the stimulus.

// File: rtl/id_rom_pkg.sv
package id_rom_pkg;
    localparam int ROM_LAST = 16;
    localparam int PTR_W    = $clog2(ROM_LAST + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e         state;
        logic [7:0]         shreg;
        logic [3:0]         bitcnt;
        logic [PTR_W-1:0]   ptr;
        logic               is_read;
        logic               mst_ack;
        logic               sda_oe;
    } tgt_regs_t;
endpackage

// File: rtl/id_rom_glitch_filter.sv
module id_rom_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [TAPS-1:0]        hist_d, hist_q;
    logic                   line_d, line_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
        hist_d = {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
        line_d = ($countones(hist_q) > HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
            line_q <= line_d;
        end
    end

    assign line_o = line_q;

    // R11
    single_pulse_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q == 3'b010) |=> !line_q);
endmodule

// File: rtl/id_rom_bus_events.sv
module id_rom_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    always_comb begin
        start_o    = scl_f && scl_prev_q && sda_prev_q && !sda_f;
        stop_o     = scl_f && scl_prev_q && !sda_prev_q && sda_f;
        scl_rise_o = scl_f && !scl_prev_q;
        scl_fall_o = !scl_f && scl_prev_q;
    end

    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/id_rom_store.sv
module id_rom_store
    import id_rom_pkg::*;
(
    input  logic [PTR_W-1:0] idx_i,
    output logic [7:0]       data_o
);
    always_comb begin
        unique case (idx_i)
            5'd0:  data_o = 8'h44;
            5'd1:  data_o = 8'h50;
            5'd2:  data_o = 8'h2D;
            5'd3:  data_o = 8'h48;
            5'd4:  data_o = 8'h44;
            5'd5:  data_o = 8'h4D;
            5'd6:  data_o = 8'h49;
            5'd7:  data_o = 8'h20;
            5'd8:  data_o = 8'h41;
            5'd9:  data_o = 8'h44;
            5'd10: data_o = 8'h41;
            5'd11: data_o = 8'h50;
            5'd12: data_o = 8'h54;
            5'd13: data_o = 8'h4F;
            5'd14: data_o = 8'h52;
            5'd15: data_o = 8'h04;
            default: data_o = 8'hFF;
        endcase
    end
endmodule

// File: rtl/id_rom_i2c_target.sv
module id_rom_i2c_target
    import id_rom_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'b1000000,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(ROM_LAST);

    logic scl_f, sda_f;
    logic start_evt, stop_evt, scl_rise, scl_fall;
    logic [PTR_W-1:0] ptr_inc, rom_idx;
    logic [7:0] rom_data;
    tgt_regs_t r_d, r_q;

    id_rom_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) scl_filt_i (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    id_rom_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) sda_filt_i (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    id_rom_bus_events events_i (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_o(start_evt), .stop_o(stop_evt),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall));

    assign ptr_inc = (r_q.ptr >= LAST_IDX) ? LAST_IDX : r_q.ptr + 1'b1;
    assign rom_idx = (r_q.state == ST_TX_ACK) ? ptr_inc : r_q.ptr;

    id_rom_store rom_i (.idx_i(rom_idx), .data_o(rom_data));

    always_comb begin
        r_d = r_q;
        if (!enable) begin
            r_d = '0;
            r_d.state = ST_IDLE;
        end else if (stop_evt) begin
            r_d.state  = ST_IDLE;
            r_d.ptr    = '0;
            r_d.sda_oe = 1'b0;
        end else if (start_evt) begin
            r_d.state  = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.sda_oe = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR, ST_PTR: begin
                    if (scl_rise) begin
                        r_d.shreg  = {r_q.shreg[6:0], sda_f};
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                        r_d.bitcnt = '0;
                        if (r_q.state == ST_PTR) begin
                            r_d.ptr    = (r_q.shreg > 8'(ROM_LAST)) ? LAST_IDX
                                                                    : r_q.shreg[PTR_W-1:0];
                            r_d.sda_oe = 1'b1;
                            r_d.state  = ST_PTR_ACK;
                        end else if (r_q.shreg[7:1] == TGT_ADDR) begin
                            r_d.is_read = r_q.shreg[0];
                            r_d.sda_oe  = 1'b1;
                            r_d.state   = ST_ADDR_ACK;
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.is_read) begin
                            r_d.shreg  = rom_data;
                            r_d.sda_oe = !rom_data[7];
                            r_d.state  = ST_TX;
                        end else begin
                            r_d.sda_oe = 1'b0;
                            r_d.state  = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall) begin
                        r_d.sda_oe = 1'b0;
                        r_d.state  = ST_IGNORE;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.bitcnt == 4'd7) begin
                            r_d.bitcnt = '0;
                            r_d.sda_oe = 1'b0;
                            r_d.state  = ST_TX_ACK;
                        end else begin
                            r_d.bitcnt = r_q.bitcnt + 1'b1;
                            r_d.shreg  = {r_q.shreg[6:0], 1'b0};
                            r_d.sda_oe = !r_q.shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        r_d.mst_ack = !sda_f;
                    end else if (scl_fall) begin
                        if (r_q.mst_ack) begin
                            r_d.ptr    = ptr_inc;
                            r_d.shreg  = rom_data;
                            r_d.sda_oe = !rom_data[7];
                            r_d.state  = ST_TX;
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.sda_oe;

    // R8
    enable_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sda_oe_o);
    // R9
    drive_when_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !$past(scl_f));
    // R7
    stop_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (r_q.ptr == '0));
    // R5
    ptr_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ptr <= LAST_IDX);
    // R1
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IGNORE && !$past(scl_fall)) |-> !sda_oe_o);
endmodule

// File: tb/id_rom_i2c_target_tb_top.sv
module id_rom_i2c_target_tb_top;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    int   oe_cnt = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    id_rom_i2c_target dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe));

    always @(posedge clk) if (sda_oe) oe_cnt++;

    function automatic logic [7:0] exp_byte(int i);
        string s = "DP-HDMI ADAPTOR";
        if (i < 15) return s[i];
        if (i == 15) return 8'h04;
        return 8'hFF;
    endfunction

    task automatic check(int act, int exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        scl = 0; wq(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
    endtask

    task automatic i2c_stop();
        scl = 0; sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(2);
    endtask

    task automatic put_bit(logic b, bit glitch, output logic seen);
        scl = 0; wq(); sda_m = b; wq(); scl = 1; wq();
        if (glitch) begin scl = 0; @(negedge clk); scl = 1; end
        seen = sda_line; wq(); scl = 0;
    endtask

    task automatic write_byte(logic [7:0] b, output bit ack, input int glitch_bit = -1);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], (i == glitch_bit), s);
        put_bit(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic read_byte(bit master_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin put_bit(1'b1, 1'b0, s); d[i] = s; end
        put_bit(!master_ack, 1'b0, s);
    endtask

    task automatic t_reset();
        check(sda_oe, 0, "R10 reset releases SDA");
    endtask

    task automatic t_full_read();
        bit ack; logic [7:0] d;
        i2c_start(); write_byte(8'h80, ack); check(ack, 1, "R1 write address ACK");
        write_byte(8'h00, ack); check(ack, 1, "R2 pointer byte ACK");
        i2c_stop();
        i2c_start(); write_byte(8'h81, ack); check(ack, 1, "R1 read address ACK");
        for (int i = 0; i < 20; i++) begin
            read_byte(i != 19, d);
            check(d, exp_byte(i), $sformatf("R3 R4 R5 byte %0d", i));
        end
        i2c_stop();
    endtask

    task automatic t_short_read();
        bit ack; logic [7:0] d;
        i2c_start(); write_byte(8'h81, ack); check(ack, 1, "R7 direct read ACK");
        read_byte(1'b1, d); check(d, exp_byte(0), "R7 direct read byte 0");
        read_byte(1'b0, d); check(d, exp_byte(1), "R7 direct read byte 1");
        i2c_stop();
    endtask

    task automatic t_ptr_rs(logic [7:0] p, int first);
        bit ack; logic [7:0] d;
        i2c_start(); write_byte(8'h80, ack); write_byte(p, ack);
        check(ack, 1, "R2 pointer ACK");
        i2c_start(); write_byte(8'h81, ack);
        for (int i = 0; i < 3; i++) begin
            read_byte(i != 2, d);
            check(d, exp_byte((first + i > 16) ? 16 : first + i), "R2 R5 pointer read");
        end
        i2c_stop();
    endtask

    task automatic t_extra_write();
        bit ack;
        i2c_start(); write_byte(8'h80, ack); write_byte(8'h03, ack);
        write_byte(8'h55, ack); check(ack, 0, "R2 second write byte NACK");
        i2c_stop();
    endtask

    task automatic t_wrong_addr();
        bit ack;
        i2c_start(); oe_cnt = 0;
        write_byte(8'h42, ack); check(ack, 0, "R1 foreign address NACK");
        write_byte(8'h00, ack); check(oe_cnt, 0, "R1 ignored until START");
        i2c_stop();
    endtask

    task automatic t_nack_release();
        bit ack; logic [7:0] d;
        i2c_start(); write_byte(8'h81, ack);
        read_byte(1'b0, d); check(d, exp_byte(0), "R6 byte before NACK");
        oe_cnt = 0;
        read_byte(1'b1, d); read_byte(1'b1, d);
        check(oe_cnt, 0, "R6 released after NACK");
        i2c_stop();
    endtask

    task automatic t_disabled();
        bit ack; logic [7:0] d;
        enable = 0; wq(); oe_cnt = 0;
        i2c_start(); write_byte(8'h81, ack); check(ack, 0, "R8 no ACK while disabled");
        read_byte(1'b1, d); check(oe_cnt, 0, "R8 SDA never driven");
        i2c_stop(); enable = 1; wq();
    endtask

    task automatic t_glitch();
        bit ack; logic [7:0] d;
        i2c_start(); write_byte(8'h81, ack, 3); check(ack, 1, "R11 SCL glitch filtered");
        read_byte(1'b0, d); check(d, exp_byte(0), "R11 data after glitch");
        i2c_stop();
        scl = 1; sda_m = 0; @(negedge clk); sda_m = 1; wq(2);
        i2c_start(); write_byte(8'h81, ack); read_byte(1'b0, d);
        check(d, exp_byte(0), "R11 SDA glitch filtered");
        i2c_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        t_reset();
        t_full_read();
        t_short_read();
        t_ptr_rs(8'h05, 5);
        t_ptr_rs(8'h30, 16);
        t_ptr_rs(8'h0F, 15);
        t_extra_write();
        t_wrong_addr();
        t_nack_release();
        t_disabled();
        t_glitch();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule